// File: doc/BRIEF.md
# Buffered SPI Master Transaction Engine

This block is a memory-mapped SPI master that carries out one complete transaction per start command. Software loads an opcode word, a 32-byte data buffer, a clock divider, the clock mode, the bit order and three bit counts, then sets the start bit. The engine asserts the selected chip selects and shifts out the opcode bits. In half-duplex mode it then shifts out data bits from the buffer and receives the programmed number of bits back into the buffer. In full-duplex mode it shifts out the lower half of the buffer while it fills the upper half.

Software polls a busy bit and reads the received bytes from the buffer words. Register writes are refused for the whole transaction, so the running sequence always works from a stable configuration.

Top module: `spi_buf_master`

## Requirements
- R1: After reset the registers at 0x00, 0x28, 0x2C and 0x38 read 0, both chip-select outputs are high, and SCK and MOSI are low.
- R2: Writing 1 to bit 8 at offset 0x00 while idle starts a transaction. Bit 16 at 0x00 reads 1 from the cycle after that write until the transaction ends. A transaction with zero total bits still runs and then clears the bit.
- R3: Bits [27:16] of the config word at 0x28 hold D. One SCK period is D+2 system cycles, so D=4095 gives 4097 cycles. The half-period before each leading edge is P-floor(P/2) cycles, where P=D+2. While idle, SCK rests at CPOL (config bit 4).
- R4: With CPHA (config bit 5) at 0, MOSI is set before the first leading edge and changes on trailing edges, and MISO is captured on leading edges. With CPHA at 1, MOSI changes on leading edges and MISO is captured on trailing edges.
- R5: In half-duplex mode (config bit 10 at 0) the bit stream has three phases in order. First come the opcode bits: count field [31:24] at 0x2C, with values above 32 treated as 32. Next come the data bits: count field [11:0], taken from buffer byte 0 upward. Last come the receive bits: count field [23:12], stored from buffer byte 0 upward. MOSI is 0 during the receive phase.
- R6: The opcode word at 0x04 is sent most significant byte first: bits [31:24] are the first byte on the wire.
- R7: The buffer is eight words at 0x08 to 0x24. Byte n is at word n/4, bits 8*(n%4)+7 down to 8*(n%4). Within each byte, bits go out and come in MSB first, or LSB first when config bit 3 is 1.
- R8: In full-duplex mode (config bit 10 at 1) the engine runs the receive count of bits. It shifts out buffer bytes 0 to 15 and at the same time stores the received bits into bytes 16 to 31, which are read from offset 0x18. The opcode and data counts are not used.
- R9: During a transaction, cs_n_o[i] is low exactly when bit i of the select mask at 0x38 is 1. The chip selects go high, and the busy bit clears, P-floor(P/2) cycles after the last SCK edge.
- R10: While busy, every register write is ignored. This includes a new start and writes to the config, count and select registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Register byte address (bits [1:0] ignored) |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| sck_o | output | 1 | SPI clock |
| mosi_o | output | 1 | Serial data out |
| cs_n_o | output | 2 | Chip selects, active low |
| miso_i | input | 1 | Serial data in |

## Verification
The bench goes after the boundaries between phases: opcode counts that are not multiples of eight, a clamped opcode count of 40, and data runs that cross word boundaries. A design that used the wrong byte of the opcode, or that split the phases at byte rather than bit granularity, would send a shifted stream or store received bits in the wrong byte. The bench runs all four clock modes against a slave model that changes MISO only on its own shift edge, so a master that samples on the wrong edge reads the neighbouring bit. It also measures the SCK period at the fastest and slowest divider and the chip-select tail, which catches off-by-one errors in the timer. Starts and config writes issued mid-transaction expose an engine that restarts or takes a changed setting.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;
  localparam int unsigned DIV_W     = 12;
  localparam int unsigned OP_MAX    = 32;
  localparam int unsigned START_BIT = 8;
  localparam int unsigned BUSY_BIT  = 16;

  // word index = byte offset / 4
  localparam logic [3:0] W_CTRL = 4'd0;
  localparam logic [3:0] W_OPC  = 4'd1;
  localparam logic [3:0] W_BUF0 = 4'd2;
  localparam logic [3:0] W_CFG  = 4'd10;
  localparam logic [3:0] W_CNT  = 4'd11;
  localparam logic [3:0] W_SEL  = 4'd14;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic             fdx;
    logic             cpha;
    logic             cpol;
    logic             lsb;
  } cfg_t;

  typedef struct packed {
    logic [7:0]  op;
    logic [11:0] rx;
    logic [11:0] tx;
  } cnt_t;

  function automatic logic [2:0] bit_in_byte(logic lsb, logic [2:0] k);
    return lsb ? k : ~k;
  endfunction
endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
  parameter int unsigned HW = 13
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [HW-1:0] len_i,
  input  logic          en_i,
  output logic          expire_o
);
  logic [HW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (load_i) cnt_q <= len_i - 1'b1;
    else if (en_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign expire_o = en_i && (cnt_q == '0);
endmodule

// File: rtl/spi_edge_seq.sv
module spi_edge_seq #(
  parameter int unsigned NB_W = 14,
  parameter int unsigned HW   = 13
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [NB_W-1:0] n_bits_i,
  input  logic [HW-1:0]   lead_len_i,
  input  logic [HW-1:0]   trail_len_i,
  input  logic            cpol_i,
  input  logic            cpha_i,
  output logic            busy_o,
  output logic            sck_o,
  output logic            drv_o,
  output logic            smp_o,
  output logic [NB_W-1:0] idx_o
);
  logic            busy_q, sck_q, expire, tmr_load, at_end, edge_ev, lead_ev, start_ok;
  logic [NB_W:0]   edge_q;
  logic [HW-1:0]   tmr_len;
  logic [NB_W-1:0] cur_bit, nxt_bit;

  assign start_ok = start_i & ~busy_q;
  assign at_end   = edge_q == {n_bits_i, 1'b0};
  assign edge_ev  = busy_q & expire & ~at_end;
  assign lead_ev  = ~edge_q[0];
  assign cur_bit  = edge_q[NB_W:1];
  assign nxt_bit  = cur_bit + 1'b1;
  assign tmr_load = start_ok | edge_ev;
  // wait before a trailing edge after a leading one, else before a leading edge
  assign tmr_len  = (edge_ev && lead_ev) ? trail_len_i : lead_len_i;

  spi_half_timer #(.HW(HW)) i_tmr (
    .clk_i, .rst_ni,
    .load_i  (tmr_load),
    .len_i   (tmr_len),
    .en_i    (busy_q),
    .expire_o(expire)
  );

  always_comb begin
    drv_o = 1'b0;
    smp_o = 1'b0;
    idx_o = cur_bit;
    if (start_ok) begin
      drv_o = ~cpha_i && (n_bits_i != '0);
      idx_o = '0;
    end else if (edge_ev) begin
      if (lead_ev) begin
        drv_o = cpha_i;
        smp_o = ~cpha_i;
      end else if (cpha_i) begin
        smp_o = 1'b1;
      end else begin
        idx_o = nxt_bit;
        drv_o = nxt_bit < n_bits_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      edge_q <= '0;
    end else if (start_ok) begin
      busy_q <= 1'b1;
      sck_q  <= cpol_i;
      edge_q <= '0;
    end else if (busy_q && expire) begin
      if (at_end) busy_q <= 1'b0;
      else begin
        sck_q  <= ~sck_q;
        edge_q <= edge_q + 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign sck_o  = busy_q ? sck_q : cpol_i;
endmodule

// File: rtl/spi_buf_master.sv
module spi_buf_master
  import spi_xfer_pkg::*;
#(
  parameter int unsigned BUF_WORDS = 8,
  parameter int unsigned NB_W      = 14
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [5:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        sck_o,
  output logic        mosi_o,
  output logic [1:0]  cs_n_o,
  input  logic        miso_i
);
  localparam int unsigned BUF_BYTES = BUF_WORDS * 4;
  localparam int unsigned BUF_BITS  = BUF_BYTES * 8;
  localparam int unsigned BYTE_IW   = $clog2(BUF_BYTES);
  localparam int unsigned HW        = DIV_W + 1;

  logic [31:0]          op_q;
  logic [BUF_BITS-1:0]  buf_q;
  cfg_t                 cfg_q;
  cnt_t                 cnt_q;
  logic [1:0]           pol_q;
  logic                 busy, wr, start, drv, smp, mosi_q, tx_bit, rx_en, sck;
  logic [3:0]           widx;
  logic [NB_W-1:0]      idx, op_n, n_bits, j;
  logic [HW-1:0]        per, lead_len, trail_len;
  logic [BYTE_IW-1:0]   tb, rb;
  logic [BYTE_IW+2:0]   rx_pos;

  assign widx  = reg_addr_i[5:2];
  assign wr    = reg_we_i & ~busy;
  assign start = wr && widx == W_CTRL && reg_wdata_i[START_BIT];

  assign op_n      = (cnt_q.op > 8'(OP_MAX)) ? NB_W'(OP_MAX) : NB_W'(cnt_q.op);
  assign n_bits    = cfg_q.fdx ? NB_W'(cnt_q.rx) : op_n + NB_W'(cnt_q.tx) + NB_W'(cnt_q.rx);
  assign per       = HW'(cfg_q.div) + HW'(2);
  assign trail_len = per >> 1;
  assign lead_len  = per - trail_len;

  spi_edge_seq #(.NB_W(NB_W), .HW(HW)) i_seq (
    .clk_i, .rst_ni,
    .start_i    (start),
    .n_bits_i   (n_bits),
    .lead_len_i (lead_len),
    .trail_len_i(trail_len),
    .cpol_i     (cfg_q.cpol),
    .cpha_i     (cfg_q.cpha),
    .busy_o     (busy),
    .sck_o      (sck),
    .drv_o      (drv),
    .smp_o      (smp),
    .idx_o      (idx)
  );

  // bit stream mapping for index idx
  always_comb begin
    tx_bit = 1'b0;
    rx_en  = 1'b0;
    j      = idx;
    tb     = '0;
    rb     = '0;
    if (cfg_q.fdx) begin
      tb    = {1'b0, idx[3 +: BYTE_IW-1]};
      rb    = {1'b1, idx[3 +: BYTE_IW-1]};
      tx_bit = buf_q[{tb, bit_in_byte(cfg_q.lsb, idx[2:0])}];
      rx_en = 1'b1;
    end else if (idx < op_n) begin
      tx_bit = op_q[{~idx[4:3], bit_in_byte(cfg_q.lsb, idx[2:0])}];
    end else if (idx < op_n + NB_W'(cnt_q.tx)) begin
      j      = idx - op_n;
      tb     = j[3 +: BYTE_IW];
      tx_bit = buf_q[{tb, bit_in_byte(cfg_q.lsb, j[2:0])}];
    end else begin
      j     = idx - op_n - NB_W'(cnt_q.tx);
      rb    = j[3 +: BYTE_IW];
      rx_en = 1'b1;
    end
    rx_pos = {rb, bit_in_byte(cfg_q.lsb, j[2:0])};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q   <= '0;
      buf_q  <= '0;
      cfg_q  <= '0;
      cnt_q  <= '0;
      pol_q  <= '0;
      mosi_q <= 1'b0;
    end else begin
      if (wr) begin
        unique case (widx)
          W_OPC: op_q <= reg_wdata_i;
          W_CFG: begin
            cfg_q.div  <= reg_wdata_i[16 +: DIV_W];
            cfg_q.fdx  <= reg_wdata_i[10];
            cfg_q.cpha <= reg_wdata_i[5];
            cfg_q.cpol <= reg_wdata_i[4];
            cfg_q.lsb  <= reg_wdata_i[3];
          end
          W_CNT: cnt_q <= reg_wdata_i;
          W_SEL: pol_q <= reg_wdata_i[1:0];
          default: ;
        endcase
        for (int w = 0; w < BUF_WORDS; w++)
          if (widx == W_BUF0 + 4'(w)) buf_q[32*w +: 32] <= reg_wdata_i;
      end
      if (smp && rx_en) buf_q[rx_pos] <= miso_i;
      if (drv) mosi_q <= tx_bit;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (widx)
      W_CTRL: reg_rdata_o[BUSY_BIT] = busy;
      W_OPC:  reg_rdata_o = op_q;
      W_CFG:  reg_rdata_o = {4'b0, cfg_q.div, 5'b0, cfg_q.fdx, 4'b0,
                             cfg_q.cpha, cfg_q.cpol, cfg_q.lsb, 3'b0};
      W_CNT:  reg_rdata_o = cnt_q;
      W_SEL:  reg_rdata_o = {30'b0, pol_q};
      default: ;
    endcase
    for (int w = 0; w < BUF_WORDS; w++)
      if (widx == W_BUF0 + 4'(w)) reg_rdata_o = buf_q[32*w +: 32];
  end

  assign sck_o  = sck;
  assign mosi_o = mosi_q;
  assign cs_n_o = busy ? ~pol_q : 2'b11;
endmodule

// File: rtl/spi_buf_master_chk.sv
module spi_buf_master_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        busy_i,
  input logic        we_i,
  input logic [5:0]  addr_i,
  input logic [31:0] wdata_i,
  input logic [15:0] cfg_i,
  input logic [31:0] cnt_i,
  input logic [1:0]  pol_i,
  input logic [1:0]  cs_ni,
  input logic        sck_i
);
  a_r9_cs_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> cs_ni == 2'b11);

  a_r9_cs_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> cs_ni == ~pol_i);

  a_r3_sck_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> sck_i == cfg_i[1]);

  a_r10_write_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && we_i |=> $stable(cfg_i) && $stable(cnt_i) && $stable(pol_i));

  a_r2_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i && we_i && addr_i[5:2] == 4'd0 && wdata_i[8] |=> busy_i);
endmodule

bind spi_buf_master spi_buf_master_chk i_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .busy_i (busy),
  .we_i   (reg_we_i),
  .addr_i (reg_addr_i),
  .wdata_i(reg_wdata_i),
  .cfg_i  (cfg_q),
  .cnt_i  (cnt_q),
  .pol_i  (pol_q),
  .cs_ni  (cs_n_o),
  .sck_i  (sck_o)
);

// File: tb/test_spi_buf_master.sv
module test_spi_buf_master;
  logic        clk = 0, rst_n = 0, we = 0, miso = 0;
  logic [5:0]  addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic        sck, mosi;
  logic [1:0]  cs_n;

  always #4 clk = ~clk;

  spi_buf_master i_spi_buf_master (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .sck_o(sck), .mosi_o(mosi),
    .cs_n_o(cs_n), .miso_i(miso)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // reference model state
  bit [7:0]    mb[32];
  bit [31:0]   m_opw;
  int          m_opn, m_dat, m_rx, m_per, m_hl;
  bit          m_lsb, m_fdx, m_cpol, m_cpha;
  bit [1023:0] pat, cap;

  // slave / monitor
  bit       p_sck = 0;
  bit [1:0] p_cs = 2'b11, cs_seen;
  int       nb, last_lead, last_edge, per_bad, tail;

  always @(negedge clk) if (rst_n) begin
    if (p_cs == 2'b11 && cs_n != 2'b11) begin
      nb = 0; last_lead = -1; per_bad = 0; cs_seen = cs_n;
      if (!m_cpha) miso = pat[0];
    end
    if (cs_n != 2'b11 && sck != p_sck) begin
      bit lead;
      lead = (sck != m_cpol);
      last_edge = cyc;
      if (lead) begin
        if (last_lead >= 0 && cyc - last_lead != m_per) per_bad++;
        last_lead = cyc;
      end
      if (lead == !m_cpha) begin cap[nb] = mosi; nb++; end
      else miso = pat[nb];
    end
    if (p_cs != 2'b11 && cs_n == 2'b11) tail = cyc - last_edge;
    p_sck = sck;
    p_cs  = cs_n;
  end

  task automatic wr(input [5:0] a, input [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input [5:0] a, output [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  function automatic bit bsel(bit [7:0] by, int k);
    return m_lsb ? by[k] : by[7-k];
  endfunction

  function automatic bit exp_tx(int i);
    int jj;
    if (m_fdx) return bsel(mb[(i/8)%16], i%8);
    if (i < m_opn) return bsel(m_opw[8*(3-i/8) +: 8], i%8);
    jj = i - m_opn;
    if (jj < m_dat) return bsel(mb[(jj/8)%32], jj%8);
    return 0;
  endfunction

  task automatic xfer(input int d, input bit cpol, input bit cpha, input bit lsb,
                      input bit fdx, input bit [1:0] pol, input bit [31:0] opw,
                      input int opc, input int dat, input int rx, input bit poke,
                      input string req, input string tag);
    bit [31:0] v, cfgw, cntw;
    bit [7:0]  eb[32];
    int n, bad;
    m_cpol = cpol; m_cpha = cpha; m_lsb = lsb; m_fdx = fdx; m_opw = opw;
    m_dat = dat; m_rx = rx; m_opn = (opc > 32) ? 32 : opc;
    m_per = d + 2; m_hl = m_per - m_per / 2;
    n = fdx ? rx : m_opn + dat + rx;
    for (int b = 0; b < 32; b++) mb[b] = 8'($urandom);
    for (int w = 0; w < 8; w++) wr(6'(8 + 4*w), {mb[4*w+3], mb[4*w+2], mb[4*w+1], mb[4*w]});
    for (int k = 0; k < 32; k++) pat[32*k +: 32] = $urandom;
    cfgw = (32'(d) << 16) | (32'(fdx) << 10) | (32'(cpha) << 5) | (32'(cpol) << 4) | (32'(lsb) << 3);
    cntw = {8'(opc), 12'(rx), 12'(dat)};
    wr(6'h04, opw); wr(6'h28, cfgw); wr(6'h2c, cntw); wr(6'h38, {30'b0, pol});
    nb = 0; tail = -1;
    wr(6'h00, 32'h100);
    rd(6'h00, v);
    chk(v[16] == 1'b1, "R2", {tag, " busy after start"}, v[16], 1);
    if (poke) begin
      wr(6'h28, cfgw ^ 32'h0003_0438);
      wr(6'h2c, 32'h0);
      wr(6'h38, {30'b0, ~pol});
      wr(6'h00, 32'h100);
    end
    do begin @(negedge clk); rd(6'h00, v); end while (v[16]);
    chk(nb == n, req, {tag, " bit count"}, nb, n);
    bad = 0;
    for (int i = 0; i < n; i++) if (cap[i] != exp_tx(i)) bad++;
    chk(bad == 0, req, {tag, " mosi stream mismatches"}, bad, 0);
    if (n > 1) chk(per_bad == 0, "R3", {tag, " sck period errors"}, per_bad, 0);
    if (n > 0) chk(tail == m_hl, "R9", {tag, " cs tail cycles"}, tail, m_hl);
    chk(cs_seen == ~pol, "R9", {tag, " cs level"}, cs_seen, ~pol);
    for (int b = 0; b < 32; b++) eb[b] = mb[b];
    for (int jx = 0; jx < rx; jx++) begin
      int bi, g, p;
      bi = fdx ? 16 + (jx/8)%16 : (jx/8)%32;
      g  = fdx ? jx : m_opn + dat + jx;
      p  = lsb ? jx%8 : 7 - jx%8;
      eb[bi][p] = pat[g];
    end
    for (int w = 0; w < 8; w++) begin
      rd(6'(8 + 4*w), v);
      chk(v == {eb[4*w+3], eb[4*w+2], eb[4*w+1], eb[4*w]}, fdx ? "R8" : "R7",
          {tag, " buffer word"}, v, {eb[4*w+3], eb[4*w+2], eb[4*w+1], eb[4*w]});
    end
    if (poke) begin
      rd(6'h28, v); chk(v == cfgw, "R10", {tag, " cfg kept"}, v, cfgw);
      rd(6'h2c, v); chk(v == cntw, "R10", {tag, " counts kept"}, v, cntw);
      repeat (30) @(negedge clk);
      rd(6'h00, v);
      chk(v[16] == 0 && cs_n == 2'b11, "R10", {tag, " no restart"}, {v[16], cs_n}, 3'b011);
    end
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  always @(posedge clk) if (cyc == 180000) begin
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected <180000 cycles", cyc);
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h1234abcd));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(6'h00, v); chk(v == 0, "R1", "ctrl reset", v, 0);
    rd(6'h28, v); chk(v == 0, "R1", "cfg reset", v, 0);
    rd(6'h2c, v); chk(v == 0, "R1", "count reset", v, 0);
    rd(6'h38, v); chk(v == 0, "R1", "select reset", v, 0);
    chk(cs_n == 2'b11 && sck == 0 && mosi == 0, "R1", "pins reset",
        {cs_n, sck, mosi}, 4'b1100);

    xfer(0, 0, 0, 0, 0, 2'b01, 32'h9FA5_0000, 8, 0, 24, 0, "R5", "mode0 op8 rx24");
    xfer(1, 0, 0, 0, 0, 2'b10, 32'hA1B2_C3D4, 32, 16, 8, 0, "R6", "op32 byte order");
    xfer(0, 1, 1, 1, 0, 2'b11, 32'h0123_4567, 11, 40, 19, 0, "R7", "lsb first mode3");
    xfer(2, 1, 0, 0, 0, 2'b01, 32'hDEAD_BEEF, 5, 9, 13, 0, "R4", "cpol1 cpha0");
    xfer(3, 0, 1, 0, 0, 2'b10, 32'hCAFE_F00D, 7, 3, 17, 0, "R4", "cpol0 cpha1");
    xfer(0, 0, 0, 0, 1, 2'b01, 32'h0, 12, 20, 128, 0, "R8", "full duplex 16 bytes");
    xfer(1, 1, 1, 0, 1, 2'b10, 32'h0, 0, 0, 37, 0, "R8", "full duplex odd count");
    xfer(0, 0, 0, 0, 0, 2'b01, 32'h5A5A_C3C3, 40, 4, 6, 0, "R5", "opcode count clamp");
    xfer(0, 0, 0, 0, 0, 2'b10, 32'h0, 0, 0, 0, 0, "R2", "zero length");
    xfer(2, 0, 0, 0, 0, 2'b01, 32'h8123_4567, 16, 16, 16, 1, "R10", "writes while busy");
    xfer(4095, 0, 1, 0, 0, 2'b01, 32'hC000_0000, 2, 0, 0, 0, "R3", "slowest divider");

    for (int r = 0; r < 14; r++) begin
      bit fx;
      fx = 1'($urandom);
      xfer(int'($urandom % 4), 1'($urandom), 1'($urandom), 1'($urandom), fx,
           2'($urandom % 3 + 1), $urandom, int'($urandom % 41),
           int'($urandom % 65), fx ? int'($urandom % 129) : int'($urandom % 97),
           0, fx ? "R8" : "R5", "random");
    end
    summary();
    $finish;
  end
endmodule